// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second operand of a data-processing operation. It takes a data word and moves it left or right by a chosen number of places, or rotates it, in a single combinational pass. It also produces the carry-out that a logical operation writes into the carry flag. The amount can come from a short immediate field or from the low byte of a register. An immediate amount of zero selects special forms: a shift by the full word width, or a one-place rotate through the carry flag.

A decoder sorts each request into one of five classes: pass-through, rotate through carry, partial shift, full-width shift, or over-range shift. A logarithmic right rotator does the data movement. Left shifts run through the same rotator with the amount negated. A per-bit mask then clears the vacated positions, or fills them with the sign bit.

Top module: `opnd_shifter`

## Requirements
- R1: With `shk_i` = 0 (left logical) and an effective amount n in 1..W-1, `res_o` = `opnd_i` << n with zeros entering at the low end, and `cy_o` = `opnd_i`[W-n].
- R2: With `shk_i` = 1 (right logical) and n in 1..W-1, `res_o` = `opnd_i` >> n with zeros entering at the high end, and `cy_o` = `opnd_i`[n-1].
- R3: With `shk_i` = 2 (right arithmetic) and n in 1..W-1, the vacated high bits are copies of `opnd_i`[W-1], and `cy_o` = `opnd_i`[n-1].
- R4: With `shk_i` = 3 (rotate right) and n in 1..W-1, bits leaving the low end enter the high end in order, and `cy_o` equals `res_o`[W-1].
- R5: When `amt_reg_i` = 0, only `amt_i`[log2(W)-1:0] forms the amount, and the upper bits of `amt_i` have no effect on either output.
- R6: With an immediate amount of 0, left logical passes `opnd_i` through with `cy_o` = `cy_i`. Right logical and right arithmetic act as shifts by exactly W.
- R7: With an immediate amount of 0 and rotate right, `res_o` = {`cy_i`, `opnd_i`[W-1:1]} and `cy_o` = `opnd_i`[0].
- R8: When `amt_reg_i` = 1 and `amt_i` = 0, `res_o` = `opnd_i` and `cy_o` = `cy_i` for every shift type.
- R9: A shift by exactly W gives the following. Left logical: result 0, carry bit 0. Right logical: result 0, carry bit W-1. Right arithmetic: result and carry all equal to bit W-1. Rotate right: result unchanged, carry bit W-1.
- R10: When `amt_reg_i` = 1 and `amt_i` > W, left and right logical give result 0 and carry 0. Right arithmetic fills the result and the carry with bit W-1. Rotate right uses the amount modulo W, and a zero remainder acts as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | W (32) | Data word to be shifted |
| shk_i | input | 2 | Shift type: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| amt_i | input | AMT_W (8) | Shift amount, either immediate (low log2(W) bits) or register byte |
| amt_reg_i | input | 1 | 1: amount comes from a register; 0: amount is an immediate field |
| cy_i | input | 1 | Current carry flag |
| res_o | output | W (32) | Shifted or rotated word |
| cy_o | output | 1 | Shifter carry-out |

## Verification
Some relations are checked on every evaluation: pass-through for a zero register amount, the rotate-through-carry form, the sign bit holding under arithmetic shifts, bit-count preservation and carry equal to the top result bit under rotation, and the zero result for over-range logical shifts. The exact bit placement and the carry of partial shifts are left to the bench's scenarios. So are the treatment of an amount of exactly W and the modulo reduction for large rotates. These are compared against a wide-word reference model over directed boundaries and seeded random stimulus. The independence from the ignored upper amount bits in immediate mode also shows only at the ports, through those scenarios.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

   typedef enum logic [2:0] {
      AC_PASS = 3'd0,
      AC_RRX  = 3'd1,
      AC_PART = 3'd2,
      AC_FULL = 3'd3,
      AC_OVER = 3'd4
   } amt_class_e;

endpackage

// File: rtl/opsh_amt_decode.sv
module opsh_amt_decode
   import opsh_pkg::*;
#(
   parameter int W     = 32,
   parameter int AMT_W = 8,
   localparam int LOG_W = $clog2(W)
) (
   input  shift_kind_e            kind_i,
   input  logic [AMT_W-1:0]       amt_i,
   input  logic                   from_reg_i,
   output amt_class_e             cls_o,
   output logic [LOG_W-1:0]       sub_o
);

   localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

   logic [LOG_W-1:0] low_bits;
   logic             reg_zero;
   logic             reg_below;
   logic             reg_equal;

   assign low_bits  = amt_i[LOG_W-1:0];
   assign reg_zero  = (amt_i == '0);
   assign reg_below = (amt_i < W_AMT);
   assign reg_equal = (amt_i == W_AMT);

   always_comb begin
      cls_o = AC_PART;
      sub_o = low_bits;
      if (!from_reg_i) begin
         if (low_bits == '0) begin
            sub_o = '0;
            unique case (kind_i)
               SK_LSL:  cls_o = AC_PASS;
               SK_ROR:  cls_o = AC_RRX;
               default: cls_o = AC_FULL;
            endcase
         end
      end else if (reg_zero) begin
         cls_o = AC_PASS;
         sub_o = '0;
      end else if (reg_below) begin
         cls_o = AC_PART;
      end else if (reg_equal) begin
         cls_o = AC_FULL;
         sub_o = '0;
      end else begin
         sub_o = '0;
         unique case (kind_i)
            SK_ASR:  cls_o = AC_FULL;
            SK_ROR: begin
               if (low_bits == '0) begin
                  cls_o = AC_FULL;
               end else begin
                  cls_o = AC_PART;
                  sub_o = low_bits;
               end
            end
            default: cls_o = AC_OVER;
         endcase
      end
   end

endmodule

// File: rtl/opsh_rotator.sv
module opsh_rotator #(
   parameter int W       = 32,
   parameter bit LOG_NET = 1'b1,
   localparam int LOG_W  = $clog2(W)
) (
   input  logic [W-1:0]     din_i,
   input  logic [LOG_W-1:0] rot_i,
   output logic [W-1:0]     dout_o
);

   generate
      if (LOG_NET) begin : g_log
         logic [W-1:0] stage [LOG_W+1];
         assign stage[0] = din_i;
         for (genvar s = 0; s < LOG_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stage[s+1] = rot_i[s]
               ? {stage[s][STEP-1:0], stage[s][W-1:STEP]}
               : stage[s];
         end
         assign dout_o = stage[LOG_W];
      end else begin : g_flat
         logic [2*W-1:0] dbl;
         assign dbl    = {din_i, din_i} >> rot_i;
         assign dout_o = dbl[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/opsh_mask_gen.sv
module opsh_mask_gen #(
   parameter int W      = 32,
   localparam int LOG_W = $clog2(W)
) (
   input  logic [LOG_W-1:0] cnt_i,
   input  logic             left_i,
   output logic [W-1:0]     keep_o
);

   logic [W-1:0] up_keep;
   logic [W-1:0] dn_keep;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam logic [LOG_W:0] IDX = (LOG_W+1)'(i);
         assign up_keep[i]     = (IDX >= {1'b0, cnt_i});
         assign dn_keep[W-1-i] = up_keep[i];
      end
   endgenerate

   assign keep_o = left_i ? up_keep : dn_keep;

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
   import opsh_pkg::*;
#(
   parameter int W       = 32,
   parameter int AMT_W   = 8,
   parameter bit LOG_NET = 1'b1
) (
   input  logic [W-1:0]     opnd_i,
   input  logic [1:0]       shk_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             amt_reg_i,
   input  logic             cy_i,
   output logic [W-1:0]     res_o,
   output logic             cy_o
);

   localparam int LOG_W = $clog2(W);

   generate
      if ((1 << LOG_W) != W || W < 4) begin : g_bad_w
         $error("opnd_shifter: W must be a power of two of at least 4");
      end
      if (AMT_W <= LOG_W) begin : g_bad_amt
         $error("opnd_shifter: AMT_W must exceed log2(W)");
      end
   endgenerate

   shift_kind_e      kind;
   amt_class_e       cls;
   logic [LOG_W-1:0] sub;
   logic [LOG_W-1:0] rot_amt;
   logic [W-1:0]     rot;
   logic [W-1:0]     keep;
   logic [W-1:0]     fill;
   logic             is_left;
   logic             sgn;

   assign kind    = shift_kind_e'(shk_i);
   assign is_left = (kind == SK_LSL);
   assign sgn     = opnd_i[W-1];
   assign fill    = {W{sgn}};
   assign rot_amt = is_left ? (LOG_W'(0) - sub) : sub;

   opsh_amt_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
      .kind_i     (kind),
      .amt_i      (amt_i),
      .from_reg_i (amt_reg_i),
      .cls_o      (cls),
      .sub_o      (sub)
   );

   opsh_rotator #(.W(W), .LOG_NET(LOG_NET)) u_rot (
      .din_i  (opnd_i),
      .rot_i  (rot_amt),
      .dout_o (rot)
   );

   opsh_mask_gen #(.W(W)) u_mask (
      .cnt_i  (sub),
      .left_i (is_left),
      .keep_o (keep)
   );

   always_comb begin
      res_o = opnd_i;
      cy_o  = cy_i;
      unique case (cls)
         AC_PASS: begin
            res_o = opnd_i;
            cy_o  = cy_i;
         end
         AC_RRX: begin
            res_o = {cy_i, opnd_i[W-1:1]};
            cy_o  = opnd_i[0];
         end
         AC_PART: begin
            unique case (kind)
               SK_LSL: begin
                  res_o = rot & keep;
                  cy_o  = rot[0];
               end
               SK_LSR: begin
                  res_o = rot & keep;
                  cy_o  = rot[W-1];
               end
               SK_ASR: begin
                  res_o = (rot & keep) | (fill & ~keep);
                  cy_o  = rot[W-1];
               end
               default: begin
                  res_o = rot;
                  cy_o  = rot[W-1];
               end
            endcase
         end
         AC_FULL: begin
            unique case (kind)
               SK_LSL: begin
                  res_o = '0;
                  cy_o  = rot[0];
               end
               SK_LSR: begin
                  res_o = '0;
                  cy_o  = rot[W-1];
               end
               SK_ASR: begin
                  res_o = fill;
                  cy_o  = sgn;
               end
               default: begin
                  res_o = rot;
                  cy_o  = rot[W-1];
               end
            endcase
         end
         AC_OVER: begin
            res_o = (kind == SK_ASR) ? fill : '0;
            cy_o  = (kind == SK_ASR) ? sgn : 1'b0;
         end
         default: begin
            res_o = opnd_i;
            cy_o  = cy_i;
         end
      endcase
   end

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input logic [W-1:0]     opnd_i,
   input logic [1:0]       shk_i,
   input logic [AMT_W-1:0] amt_i,
   input logic             amt_reg_i,
   input logic             cy_i,
   input logic [W-1:0]     res_o,
   input logic             cy_o
);

   localparam int LOG_W = $clog2(W);
   localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

   logic imm_zero;
   logic eff_nonzero;

   assign imm_zero    = !amt_reg_i && (amt_i[LOG_W-1:0] == '0);
   assign eff_nonzero = amt_reg_i ? (amt_i != '0) : !imm_zero;

   always_comb begin
      if (amt_reg_i && amt_i == '0) begin
         // R8
         reg_zero_pass_chk: assert (res_o == opnd_i && cy_o == cy_i)
            else $error("register amount 0 altered operand");
      end
      if (imm_zero && shk_i == 2'd0) begin
         // R6
         imm_lsl_zero_chk: assert (res_o == opnd_i && cy_o == cy_i)
            else $error("immediate LSL 0 altered operand");
      end
      if (imm_zero && shk_i == 2'd3) begin
         // R7
         rrx_form_chk: assert (res_o == {cy_i, opnd_i[W-1:1]} && cy_o == opnd_i[0])
            else $error("rotate through carry wrong");
      end
      if (shk_i == 2'd2) begin
         // R3
         asr_sign_keep_chk: assert (res_o[W-1] == opnd_i[W-1])
            else $error("arithmetic shift lost sign");
      end
      if (shk_i == 2'd3 && eff_nonzero) begin
         // R4
         ror_popcount_chk: assert ($countones(res_o) == $countones(opnd_i) && cy_o == res_o[W-1])
            else $error("rotate changed bit count or carry");
      end
      if (amt_reg_i && amt_i > W_AMT && shk_i[1] == 1'b0) begin
         // R10
         logic_over_zero_chk: assert (res_o == '0 && !cy_o)
            else $error("over-range logical shift not zero");
      end
   end

endmodule

bind opnd_shifter opnd_shifter_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
   .opnd_i    (opnd_i),
   .shk_i     (shk_i),
   .amt_i     (amt_i),
   .amt_reg_i (amt_reg_i),
   .cy_i      (cy_i),
   .res_o     (res_o),
   .cy_o      (cy_o)
);

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;

   logic        clk = 1'b0;
   logic [31:0] opnd = '0;
   logic [1:0]  shk = '0;
   logic [7:0]  amt = '0;
   logic        amt_reg = 1'b0;
   logic        cy = 1'b0;
   logic [31:0] res;
   logic        cyo;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   opnd_shifter u_dut (
      .opnd_i    (opnd),
      .shk_i     (shk),
      .amt_i     (amt),
      .amt_reg_i (amt_reg),
      .cy_i      (cy),
      .res_o     (res),
      .cy_o      (cyo)
   );

   function automatic logic [32:0] ref_fn(logic [31:0] d, logic [1:0] k,
                                          logic [7:0] a, logic r, logic c);
      int n;
      logic [63:0] wide;
      logic signed [63:0] sw;
      logic [31:0] o;
      n = r ? int'(a) : int'(a[4:0]);
      if (n == 0) begin
         if (r || k == 2'd0) return {c, d};
         if (k == 2'd3) return {d[0], c, d[31:1]};
         n = 32;
      end
      case (k)
         2'd0: begin
            wide = {32'b0, d} << n;
            return {wide[32], wide[31:0]};
         end
         2'd1: begin
            wide = {d, 32'b0} >> n;
            return {wide[31], wide[63:32]};
         end
         2'd2: begin
            sw = $signed({d, 32'b0}) >>> ((n > 63) ? 63 : n);
            return {sw[31], sw[63:32]};
         end
         default: begin
            wide = {d, d} >> (n % 32);
            o = wide[31:0];
            return {o[31], o};
         end
      endcase
   endfunction

   function automatic string tag_of(logic [1:0] k, logic [7:0] a, logic r);
      if (!r && a[7:5] != 3'd0) return "R5";
      if (!r && a[4:0] == 5'd0) return (k == 2'd3) ? "R7" : "R6";
      if (r && a == 8'd0) return "R8";
      if (r && a == 8'd32) return "R9";
      if (r && a > 8'd32) return "R10";
      case (k)
         2'd0: return "R1";
         2'd1: return "R2";
         2'd2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic apply(logic [31:0] d, logic [1:0] k, logic [7:0] a,
                        logic r, logic c);
      logic [32:0] exp;
      @(posedge clk);
      opnd = d; shk = k; amt = a; amt_reg = r; cy = c;
      @(negedge clk);
      exp = ref_fn(d, k, a, r, c);
      n_chk++;
      if ({cyo, res} !== exp) begin
         n_err++;
         $display("FAIL %s: k=%0d amt=%0d reg=%0b d=%h cin=%0b got res=%h cy=%0b exp res=%h cy=%0b",
                  tag_of(k, a, r), k, a, r, d, c, res, cyo, exp[31:0], exp[32]);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: run hung, got timeout exp completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // idle state with zero inputs (R6 pass-through)
      apply(32'h0, 2'd0, 8'd0, 1'b0, 1'b0);
      // R1 R2 R3 R4 partial shifts
      apply(32'h8000_0001, 2'd0, 8'd1, 1'b0, 1'b0);
      apply(32'h8000_0001, 2'd0, 8'd31, 1'b0, 1'b1);
      apply(32'h8000_0001, 2'd1, 8'd1, 1'b0, 1'b0);
      apply(32'h8000_0003, 2'd1, 8'd31, 1'b1, 1'b0);
      apply(32'h8000_00F0, 2'd2, 8'd4, 1'b0, 1'b0);
      apply(32'h7FFF_FFFF, 2'd2, 8'd31, 1'b1, 1'b1);
      apply(32'h1234_5678, 2'd3, 8'd8, 1'b0, 1'b0);
      apply(32'h0000_0001, 2'd3, 8'd1, 1'b1, 1'b0);
      // R5 upper immediate bits ignored
      apply(32'hDEAD_BEEF, 2'd1, 8'hE4, 1'b0, 1'b0);
      apply(32'hDEAD_BEEF, 2'd0, 8'h20, 1'b0, 1'b1);
      // R6 R7 immediate zero forms
      apply(32'hF000_000F, 2'd0, 8'd0, 1'b0, 1'b1);
      apply(32'hF000_000F, 2'd1, 8'd0, 1'b0, 1'b0);
      apply(32'h8000_0000, 2'd2, 8'd0, 1'b0, 1'b0);
      apply(32'h0000_0003, 2'd3, 8'd0, 1'b0, 1'b1);
      apply(32'h0000_0002, 2'd3, 8'd0, 1'b0, 1'b0);
      // R8 register zero on all kinds
      for (int k = 0; k < 4; k++) apply(32'hA5A5_5A5A, 2'(k), 8'd0, 1'b1, 1'b1);
      // R9 exactly 32
      for (int k = 0; k < 4; k++) apply(32'h8000_0001, 2'(k), 8'd32, 1'b1, 1'b0);
      // R10 beyond 32
      for (int k = 0; k < 4; k++) begin
         apply(32'hC000_0001, 2'(k), 8'd33, 1'b1, 1'b1);
         apply(32'h8765_4321, 2'(k), 8'd64, 1'b1, 1'b0);
         apply(32'h8765_4321, 2'(k), 8'd255, 1'b1, 1'b0);
         apply(32'h4765_4321, 2'(k), 8'd100, 1'b1, 1'b1);
      end
      // seeded random mix
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] a;
         a = 8'($urandom);
         if (i % 4 == 0) a = 8'($urandom_range(30, 34));
         apply($urandom, 2'($urandom), a, 1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule